// File: doc/BRIEF.md
# Serial Transmitter with Word FIFO

This block is the transmit side of a synchronous serial port. The host writes 32 bits at a time. Each write becomes two 16-bit words in a 30-entry buffer: the low half goes in first, then the high half. A 16-bit shift register takes the oldest buffered word each time a frame sync is seen on an active bit-clock edge. It then sends that word one bit per active edge on the serial output.

The bit clock can come from a dedicated pin or from the receive clock. Software also chooses the active edge (rising or falling) and the bit order (MSB or LSB first). All inputs are sampled in the system clock domain, and a shift step happens two system clocks after an active bit-clock transition. The host sees the buffer level and the empty and full flags. A sticky underrun flag records any frame that started while the buffer was empty.

The shifter is a two-state machine. ST_IDLE holds the serial output low and waits for a frame sync. ST_SHIFT drives the current word. The transitions are:
- LOAD: a frame sync on an active edge, from either state, enters ST_SHIFT.
- STEP: an active edge inside ST_SHIFT with bits still remaining stays in ST_SHIFT.
- DONE: the active edge after the sixteenth bit returns to ST_IDLE.

Top module: `sertx_word_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, txd is 0 and underrun is 0.
- R2: An accepted write stores wr_data[15:0] and then wr_data[31:16] as two separate entries, in that order, and raises level by 2.
- R3: A write made when fewer than two entries are free (level 29 or 30) is ignored: level and the buffered contents are unchanged.
- R4: full is 1 exactly when level is 30, and empty is 1 exactly when level is 0.
- R5: A frame sync seen on an active edge loads the oldest word. Sixteen bits follow, one per active edge starting with the loading edge. On the next active edge without a frame sync, txd returns to 0 and stays there until the next frame sync.
- R6: With lsb_first = 0, bit 15 is sent first. With lsb_first = 1, bit 0 is sent first.
- R7: With edge_fall = 0, rising bit-clock edges are active. With edge_fall = 1, falling edges are active.
- R8: With clk_sel = 2'b10 the bit clock is pin_clk. With any other value it is rx_clk. Activity on the clock that is not selected has no effect on txd or level.
- R9: A frame sync that arrives while the buffer is empty sends sixteen zero bits and sets underrun. underrun then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 32 | Host write data, two 16-bit words |
| clk_sel | input | 2 | Bit clock source, 2'b10 selects pin_clk |
| pin_clk | input | 1 | Dedicated bit clock pin |
| rx_clk | input | 1 | Receive-side bit clock |
| edge_fall | input | 1 | 1 makes falling edges active |
| lsb_first | input | 1 | 1 sends bit 0 first |
| fsync | input | 1 | Transmit frame sync |
| txd | output | 1 | Serial data output |
| level | output | 5 | Number of buffered words |
| empty | output | 1 | Buffer holds no word |
| full | output | 1 | Buffer holds 30 words |
| underrun | output | 1 | Sticky: a frame started with an empty buffer |

## Verification
The hardest case to reach is the refusal of a write at level 29. The buffer first has to be driven to 30 by fifteen full writes, then drained by exactly one frame, and only then written again. Proving that the refused data never appears takes one more step. The stimulus sends all 29 remaining frames, and the scoreboard checks every word against the queue that the driver built. The same sequence also covers the refused write at level 30 and the full flag.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int WORD_W = 16;
    localparam logic [1:0] PIN_CLK_SEL = 2'b10;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_t;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 30,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2*W-1:0] wr_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_ok = wr_en && (count <= CW'(DEPTH - 2));
        rd_ok = pop && (count != '0);
        head  = mem[rp];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp]      <= wr_data[W-1:0];
            mem[nxt(wp)] <= wr_data[2*W-1:W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= nxt(nxt(wp));
            if (rd_ok) rp <= nxt(rp);
            count <= count + (wr_ok ? CW'(2) : CW'(0)) - (rd_ok ? CW'(1) : CW'(0));
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_reject_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count > CW'(DEPTH - 2)) |=> count <= $past(count));
    assert_pair_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count <= CW'(DEPTH - 2) && !pop) |=> count == $past(count) + CW'(2));
endmodule

// File: rtl/sertx_clk_edge.sv
module sertx_clk_edge
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       pin_clk,
    input  logic       rx_clk,
    input  logic       edge_fall,
    output logic       tick
);
    logic bsel, s1, s2;

    always_comb bsel = ((clk_sel == PIN_CLK_SEL) ? pin_clk : rx_clk) ^ edge_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= bsel;
            s2 <= s1;
        end
    end

    always_comb tick = s1 && !s2;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fsync,
    input  logic              lsb_first,
    input  logic [WORD_W-1:0] head,
    input  logic              fifo_empty,
    output logic              pop,
    output logic              txd,
    output logic              underrun
);
    localparam int CNT_W = $clog2(WORD_W);

    tx_state_t         state, state_nx;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;
    logic              load, step;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        step     = 1'b0;
        pop      = 1'b0;
        if (tick && fsync) begin
            load     = 1'b1;
            pop      = !fifo_empty;
            state_nx = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_SHIFT: begin
                    if (tick && cnt == '0) state_nx = ST_IDLE;
                    else if (tick)         step     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            cnt      <= '0;
            underrun <= 1'b0;
        end else if (load) begin
            sreg <= fifo_empty ? '0 : head;
            cnt  <= CNT_W'(WORD_W - 1);
            if (fifo_empty) underrun <= 1'b1;
        end else if (step) begin
            sreg <= lsb_first ? (sreg >> 1) : (sreg << 1);
            cnt  <= cnt - 1'b1;
        end
    end

    always_comb txd = (state == ST_SHIFT) && (lsb_first ? sreg[0] : sreg[WORD_W-1]);

    assert_sticky_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    assert_empty_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fsync && fifo_empty) |=> underrun);
    assert_frame_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !tick) |=> state == ST_SHIFT);
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !txd);
endmodule

// File: rtl/sertx_word_fifo.sv
module sertx_word_fifo
    import sertx_pkg::*;
#(
    parameter int DEPTH = 30,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic [1:0]         clk_sel,
    input  logic               pin_clk,
    input  logic               rx_clk,
    input  logic               edge_fall,
    input  logic               lsb_first,
    input  logic               fsync,
    output logic               txd,
    output logic [LVL_W-1:0]   level,
    output logic               empty,
    output logic               full,
    output logic               underrun
);
    logic              tick, pop;
    logic [WORD_W-1:0] head;

    sertx_clk_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .pin_clk   (pin_clk),
        .rx_clk    (rx_clk),
        .edge_fall (edge_fall),
        .tick      (tick)
    );

    sertx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .head    (head),
        .count   (level),
        .empty   (empty),
        .full    (full)
    );

    sertx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fsync      (fsync),
        .lsb_first  (lsb_first),
        .head       (head),
        .fifo_empty (empty),
        .pop        (pop),
        .txd        (txd),
        .underrun   (underrun)
    );
endmodule

// File: tb/sertx_word_fifo_tb.sv
`timescale 1ns/1ps
module sertx_word_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  clk_sel = 2'b00;
    logic        pin_clk = 1'b0, rx_clk = 1'b0;
    logic        edge_fall = 1'b0, lsb_first = 1'b0, fsync = 1'b0;
    logic        txd, empty, full, underrun;
    logic [4:0]  level;

    int checks = 0, errors = 0, mlevel = 0;
    bit use_pin = 0, done = 0;
    logic [15:0] expq[$];

    always #2.5 clk = ~clk;

    sertx_word_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clk_sel(clk_sel), .pin_clk(pin_clk), .rx_clk(rx_clk),
        .edge_fall(edge_fall), .lsb_first(lsb_first), .fsync(fsync),
        .txd(txd), .level(level), .empty(empty), .full(full), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_bclk(input logic v);
        if (use_pin) pin_clk = v;
        else         rx_clk = v;
    endtask

    // one active edge; returns txd just before it
    task automatic active_edge(output logic smp);
        set_bclk(edge_fall);
        wait_clks(4);
        smp = txd;
        set_bclk(~edge_fall);
        wait_clks(4);
    endtask

    // driver: host write, model pushes expected words
    task automatic host_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (mlevel <= 28) begin
            expq.push_back(d[15:0]);
            expq.push_back(d[31:16]);
            mlevel += 2;
        end
        wait_clks(1);
    endtask

    // monitor: receives one frame and compares with scoreboard
    task automatic run_frame(input string req);
        logic        b;
        logic [15:0] got, exp;
        bit          was_empty;
        got = '0;
        was_empty = (expq.size() == 0);
        fsync = 1'b1;
        active_edge(b);
        fsync = 1'b0;
        for (int i = 0; i < 16; i++) begin
            active_edge(b);
            if (lsb_first) got[i] = b;
            else           got[15-i] = b;
        end
        if (was_empty) exp = '0;
        else begin
            exp = expq.pop_front();
            mlevel--;
        end
        check(got == exp, req, {16'h0, got}, {16'h0, exp});
        check(txd == 1'b0, "R5 idle after frame", {31'h0, txd}, 32'h0);
        check(level == 5'(mlevel), "R2 level", {27'h0, level}, mlevel);
        if (was_empty)
            check(underrun == 1'b1, "R9 underrun set", {31'h0, underrun}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic b;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        // R1 reset state
        check(level == 0 && empty && !full, "R1 status", {27'h0, level}, 32'h0);
        check(!txd && !underrun, "R1 txd/underrun", {30'h0, txd, underrun}, 32'h0);
        check(!full && empty, "R4 empty at zero", {30'h0, full, empty}, 32'h1);

        // R2, R5, R6 MSB first on rising rx_clk
        host_write(32'h1234_ABCD);
        check(level == 2, "R2 pair push", {27'h0, level}, 32'h2);
        run_frame("R2 low half first / R6 msb");
        run_frame("R2 high half second");

        // R6 LSB first
        lsb_first = 1'b1;
        host_write(32'h8001_00F0);
        run_frame("R6 lsb first");
        run_frame("R6 lsb first high");
        lsb_first = 1'b0;

        // R7 falling edge
        edge_fall = 1'b1;
        rx_clk = 1'b1;
        wait_clks(4);
        host_write(32'h5A5A_C3C3);
        run_frame("R7 falling edge");
        run_frame("R7 falling edge high");
        edge_fall = 1'b0;
        rx_clk = 1'b0;
        wait_clks(4);

        // R8 unselected clock ignored
        host_write(32'h0F0F_7E81);
        clk_sel = 2'b10;
        use_pin = 1;
        wait_clks(4);
        fsync = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rx_clk = 1'b1; wait_clks(4);
            rx_clk = 1'b0; wait_clks(4);
        end
        fsync = 1'b0;
        check(level == 5'(mlevel), "R8 rx_clk ignored level", {27'h0, level}, mlevel);
        check(txd == 1'b0, "R8 rx_clk ignored txd", {31'h0, txd}, 32'h0);
        run_frame("R8 pin clock");
        run_frame("R8 pin clock high");
        clk_sel = 2'b00;
        use_pin = 0;
        wait_clks(4);

        // R9 underrun
        run_frame("R9 zeros on empty");
        host_write(32'hFFFF_1111);
        run_frame("R9 frame after underrun");
        check(underrun == 1'b1, "R9 sticky", {31'h0, underrun}, 32'h1);
        run_frame("R9 second word");

        // R3, R4 fill and reject
        for (int i = 0; i < 15; i++) host_write(32'h0100_0000 * i + 32'h0002_0001 * i + 32'hA000_0000);
        check(level == 30 && full && !empty, "R4 full at 30", {27'h0, level}, 32'd30);
        host_write(32'hDEAD_BEEF);
        check(level == 30, "R3 reject at 30", {27'h0, level}, 32'd30);
        run_frame("R3 drain one");
        check(level == 29 && !full, "R4 not full at 29", {27'h0, level}, 32'd29);
        host_write(32'hBAD0_BAD1);
        check(level == 29, "R3 reject at 29", {27'h0, level}, 32'd29);
        while (expq.size() > 0) run_frame("R3 contents intact");
        check(empty && level == 0, "R4 empty after drain", {27'h0, level}, 32'h0);
        active_edge(b);
        check(txd == 1'b0, "R5 stays low without sync", {31'h0, txd}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule